// File: doc/BRIEF.md
# Single-Wire Consumer-Control Bit Transmitter with Release Error Check

This block sends a stream of bits onto an open-drain, single-wire consumer-electronics control line. Each bit starts with the line pulled low. The drive is then let go at a point that encodes the value: 12 ticks for a logical 1 and 30 ticks for a logical 0. The next bit's falling edge comes 48 ticks after the current one. All timing is counted in strobes from one external timebase (`tick`), nominally 50 µs apart. The caller offers bits one at a time through a valid/ready handshake. One bit can wait in a holding slot while the current bit is on the wire. When a bit finishes and no bit is waiting, the message ends and the block returns to idle.

Once the drive has been let go, the block watches the synchronised line. A low level inside the check window means another device is pulling the line when it should not. In that case the block sets a sticky error flag, releases the line, discards any waiting bit and goes idle. The window opens two ticks after the release point. It closes at tick 41 under standard tolerance and at tick 37 under extended tolerance. Bits marked as follower-driven, such as an acknowledge slot, are never checked. Framing, arbitration and retrying a failed message belong to the caller.

Top module: `cec_bit_tx`

## Requirements
- R1: After a bit launches, `line_drive_low` stays 1 for exactly 12 ticks when `bit_val`=1 (logical 1) and for exactly 30 ticks when `bit_val`=0 (logical 0), then goes to 0.
- R2: If a bit is waiting when the current bit reaches 48 ticks, the next falling edge of the drive is launched on that tick. If no bit is waiting, `busy` falls and the drive stays released.
- R3: For a bit with `bit_follower`=0, a synchronised low on `line_in` sets `tx_err` when the bit's tick count is at least the release point plus 2 and below 41 (`tol_ext`=0) or below 37 (`tol_ext`=1).
- R4: When `tx_err` is set, the line is released and `busy` is 0 at once, and a bit waiting in the holding slot is discarded without being sent.
- R5: `irq` is 1 exactly when `tx_err` is 1 and `irq_en` was 1 on the previous cycle.
- R6: `tx_err` stays set until a one-cycle `err_clr` pulse. While it is set, `bit_ready` is 0 and `bit_valid` launches nothing.
- R7: A low on the line before the release point plus 2 ticks, or at or after the tolerance-selected window end, does not set `tx_err`.
- R8: A bit offered with `bit_follower`=1 never sets `tx_err`, whatever the line does.
- R9: During and after synchronous reset, `line_drive_low`, `busy`, `tx_err` and `irq` are 0 and `bit_ready` is 1.
- R10: The block accepts one bit into its holding slot while a bit is on the wire. `bit_ready` is 0 while that slot is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase strobe, one per bit-timing tick |
| tol_ext | input | 1 | 1 selects extended tolerance (earlier window end) |
| irq_en | input | 1 | Error interrupt enable |
| bit_valid | input | 1 | A bit is offered |
| bit_val | input | 1 | Value of the offered bit (1 = logical 1) |
| bit_follower | input | 1 | Offered bit is driven by a follower; skip the low check |
| bit_ready | output | 1 | Holding slot can accept a bit |
| err_clr | input | 1 | Write-one-to-clear pulse for the error flag |
| line_in | input | 1 | Sensed line level (asynchronous) |
| line_drive_low | output | 1 | 1 pulls the line low, 0 leaves it at high impedance |
| busy | output | 1 | A bit is being timed on the line |
| tx_err | output | 1 | Sticky transmit error flag |
| irq | output | 1 | Error interrupt request |

## Verification
On every cycle the assertions check how the flag, the interrupt and the drive relate to each other. The interrupt never appears without the flag, and it follows the flag one cycle after the enable. The flag stays set until cleared. While it is set the line is released and the block is idle, and a falling edge of the drive only ever comes during an active bit. Pulse widths, the 48-tick spacing of consecutive bits, the exact window edges under each tolerance, follower masking and the dropping of a waiting bit depend on tick counts across a whole bit. Only the bench scenarios show these, using a scoreboard that counts ticks on the drive output and injects lows on the line at chosen tick positions.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;
  typedef struct packed {
    logic val;
    logic follower;
  } cec_bit_t;
endpackage

// File: rtl/cec_line_sync.sv
module cec_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/cec_bit_hold.sv
module cec_bit_hold
  import cec_tx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     push,
  input  cec_bit_t push_bit,
  input  logic     pop,
  input  logic     flush,
  output logic     full,
  output cec_bit_t data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (flush)     full <= 1'b0;
      else if (push) full <= 1'b1;
      else if (pop)  full <= 1'b0;
      if (push) data <= push_bit;
    end
  end
endmodule

// File: rtl/cec_bit_timer.sv
module cec_bit_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (start)       cnt <= '0;
    else if (run && tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cec_bit_tx.sv
module cec_bit_tx
  import cec_tx_pkg::*;
#(
  parameter int ONE_REL    = 12,
  parameter int ZERO_REL   = 30,
  parameter int PERIOD     = 48,
  parameter int SETTLE     = 2,
  parameter int WEND_STD   = 41,
  parameter int WEND_EXT   = 37,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic tol_ext,
  input  logic irq_en,
  input  logic bit_valid,
  input  logic bit_val,
  input  logic bit_follower,
  output logic bit_ready,
  input  logic err_clr,
  input  logic line_in,
  output logic line_drive_low,
  output logic busy,
  output logic tx_err,
  output logic irq
);
  localparam int CNT_W = $clog2(PERIOD);
  localparam logic [CNT_W-1:0] ONE_R   = CNT_W'(ONE_REL);
  localparam logic [CNT_W-1:0] ZERO_R  = CNT_W'(ZERO_REL);
  localparam logic [CNT_W-1:0] LAST_T  = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] W_STD   = CNT_W'(WEND_STD);
  localparam logic [CNT_W-1:0] W_EXT   = CNT_W'(WEND_EXT);
  localparam logic [CNT_W-1:0] SET_T   = CNT_W'(SETTLE);

  logic             line_s;
  logic [CNT_W-1:0] cnt;
  logic             hold_full;
  cec_bit_t         hold_data, cur, offered;
  logic             accept, launch, bit_end, err_hit, err_d;
  logic [CNT_W-1:0] rel, chk_lo, chk_hi;

  assign offered = '{val: bit_val, follower: bit_follower};
  assign bit_ready = !hold_full && !tx_err;
  assign accept    = bit_valid && bit_ready;

  assign rel    = cur.val ? ONE_R : ZERO_R;
  assign chk_lo = rel + SET_T;
  assign chk_hi = tol_ext ? W_EXT : W_STD;

  assign err_hit = busy && !cur.follower && (cnt >= chk_lo) && (cnt < chk_hi) && !line_s;
  assign bit_end = busy && tick && (cnt == LAST_T);
  assign launch  = hold_full && !tx_err && !err_hit && (!busy || bit_end);
  assign err_d   = err_hit || (tx_err && !err_clr);

  cec_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(line_in), .sync_out(line_s)
  );

  cec_bit_hold u_hold (
    .clk(clk), .rst(rst), .push(accept), .push_bit(offered),
    .pop(launch), .flush(err_hit), .full(hold_full), .data(hold_data)
  );

  cec_bit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .start(launch), .run(busy), .tick(tick), .cnt(cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy           <= 1'b0;
      line_drive_low <= 1'b0;
      cur            <= '0;
      tx_err         <= 1'b0;
      irq            <= 1'b0;
    end else begin
      tx_err <= err_d;
      irq    <= err_d && irq_en;
      if (err_hit) begin
        busy           <= 1'b0;
        line_drive_low <= 1'b0;
      end else if (launch) begin
        busy           <= 1'b1;
        line_drive_low <= 1'b1;
        cur            <= hold_data;
      end else begin
        if (bit_end) busy <= 1'b0;
        if (busy && tick && (cnt == rel - 1'b1)) line_drive_low <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cec_bit_tx_chk.sv
module cec_bit_tx_chk (
  input logic clk,
  input logic rst,
  input logic line_drive_low,
  input logic busy,
  input logic tx_err,
  input logic irq,
  input logic irq_en,
  input logic err_clr
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!line_drive_low && !busy && !tx_err && !irq)); // R9
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst) irq |-> tx_err); // R5
  AST_IRQ_FOLLOWS_EN: assert property (@(posedge clk) disable iff (rst) (tx_err && $past(irq_en)) |-> irq); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst) (tx_err && !err_clr) |=> tx_err); // R6
  AST_FLAG_RELEASES: assert property (@(posedge clk) disable iff (rst) tx_err |-> (!line_drive_low && !busy)); // R4
  AST_LAUNCH_IN_BIT: assert property (@(posedge clk) disable iff (rst) $rose(line_drive_low) |-> busy); // R2
endmodule

bind cec_bit_tx cec_bit_tx_chk u_chk (
  .clk(clk), .rst(rst), .line_drive_low(line_drive_low), .busy(busy),
  .tx_err(tx_err), .irq(irq), .irq_en(irq_en), .err_clr(err_clr)
);

// File: tb/sim_cec_bit_tx.sv
module sim_cec_bit_tx;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, tol_ext = 1'b0, irq_en = 1'b1;
  logic bit_valid = 1'b0, bit_val = 1'b0, bit_follower = 1'b0, err_clr = 1'b0;
  logic force_low = 1'b0;
  logic bit_ready, line_drive_low, busy, tx_err, irq, line_in;

  int checks = 0, fails = 0;
  int exp_q[$];
  int bt = 999, low_ticks = 0;
  logic prev_drv = 1'b0, prev_busy = 1'b0;

  assign line_in = !(line_drive_low || force_low);

  always #4 clk = ~clk;

  cec_bit_tx u0 (
    .clk(clk), .rst(rst), .tick(tick), .tol_ext(tol_ext), .irq_en(irq_en),
    .bit_valid(bit_valid), .bit_val(bit_val), .bit_follower(bit_follower),
    .bit_ready(bit_ready), .err_clr(err_clr), .line_in(line_in),
    .line_drive_low(line_drive_low), .busy(busy), .tx_err(tx_err), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // timebase: one strobe every 4 clocks
  initial forever begin
    repeat (3) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  end

  // monitor / scoreboard
  initial forever begin
    @(posedge clk); #1;
    if (prev_drv && tick) low_ticks++;
    if (prev_busy && tick) bt++;
    if (!prev_drv && line_drive_low) begin
      if (prev_busy) chk(bt == 48, "R2 bit spacing ticks", bt, 48);
      bt = 0;
      low_ticks = 0;
    end
    if (prev_drv && !line_drive_low && busy) begin
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected bit", low_ticks, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(low_ticks == e, "R1 low width ticks", low_ticks, e);
      end
    end
    if (prev_busy && !busy) bt = 999;
    prev_drv = line_drive_low;
    prev_busy = busy;
  end

  task automatic send_bit(input bit v, input bit f);
    @(posedge clk); #2;
    while (!bit_ready) begin @(posedge clk); #2; end
    bit_valid = 1'b1; bit_val = v; bit_follower = f;
    exp_q.push_back(v ? 12 : 30);
    @(posedge clk); #2;
    bit_valid = 1'b0;
  endtask

  task automatic wait_bt(input int n);
    do begin @(posedge clk); #2; end while (bt != n);
  endtask

  task automatic wait_idle();
    do begin @(posedge clk); #2; end while (busy);
  endtask

  task automatic clear_err();
    err_clr = 1'b1;
    @(posedge clk); #2;
    err_clr = 1'b0;
  endtask

  task automatic inject_and_expect(input bit v, input bit tol, input int at, input bit hit, input string tag);
    tol_ext = tol;
    send_bit(v, 1'b0);
    wait_bt(at);
    force_low = 1'b1;
    if (hit) begin
      repeat (4) begin @(posedge clk); #2; end
      chk(tx_err == 1'b1, tag, tx_err, 1);
    end else begin
      wait_idle();
      chk(tx_err == 1'b0, tag, tx_err, 0);
    end
    force_low = 1'b0;
    exp_q.delete();
    if (tx_err) clear_err();
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2;
    chk(!line_drive_low && !busy && !tx_err && !irq, "R9 reset outputs quiet", line_drive_low, 0);
    rst = 1'b0;
    @(posedge clk); #2;
    chk(bit_ready == 1'b1, "R9 ready after reset", bit_ready, 1);

    // back-to-back message
    send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);
    chk(bit_ready == 1'b0, "R10 ready low while slot full", bit_ready, 0);
    send_bit(1'b0, 1'b0);
    send_bit(1'b1, 1'b0);
    wait_idle();
    chk(!line_drive_low && !tx_err, "R2 idle and released at message end", line_drive_low, 0);
    chk(exp_q.size() == 0, "R1 all bits observed", exp_q.size(), 0);

    // error during a logical 1, with a bit waiting
    tol_ext = 1'b0; irq_en = 1'b1;
    send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);
    wait_bt(20);
    force_low = 1'b1;
    repeat (4) begin @(posedge clk); #2; end
    chk(tx_err == 1'b1, "R3 error in window", tx_err, 1);
    chk(!line_drive_low && !busy, "R4 released on error", busy, 0);
    chk(irq == 1'b1, "R5 irq with enable", irq, 1);
    force_low = 1'b0;
    begin
      bit launched = 1'b0;
      repeat (60) begin @(posedge clk); #2; if (line_drive_low || busy) launched = 1'b1; end
      chk(!launched, "R4 waiting bit discarded", launched, 0);
    end
    exp_q.delete();

    // start ignored while flag set
    bit_valid = 1'b1; bit_val = 1'b1;
    begin
      bit moved = 1'b0;
      repeat (20) begin @(posedge clk); #2; if (line_drive_low || busy || bit_ready) moved = 1'b1; end
      chk(!moved, "R6 start ignored while flagged", moved, 0);
    end
    bit_valid = 1'b0;
    chk(tx_err == 1'b1, "R6 flag sticky", tx_err, 1);
    clear_err();
    chk(!tx_err && !irq, "R6 flag cleared", tx_err, 0);

    // interrupt disabled
    irq_en = 1'b0;
    send_bit(1'b0, 1'b0);
    wait_bt(34);
    force_low = 1'b1;
    repeat (4) begin @(posedge clk); #2; end
    chk(tx_err == 1'b1 && irq == 1'b0, "R5 no irq when disabled", irq, 0);
    force_low = 1'b0;
    irq_en = 1'b1;
    @(posedge clk); #2;
    chk(irq == 1'b1, "R5 irq after enabling", irq, 1);
    clear_err();
    exp_q.delete();

    // follower bit never flags
    send_bit(1'b1, 1'b1);
    wait_bt(20);
    force_low = 1'b1;
    wait_bt(40);
    force_low = 1'b0;
    wait_idle();
    chk(tx_err == 1'b0, "R8 follower bit not checked", tx_err, 0);

    // low just before window opens
    send_bit(1'b0, 1'b0);
    wait_bt(30);
    force_low = 1'b1;
    wait_bt(31);
    force_low = 1'b0;
    wait_idle();
    chk(tx_err == 1'b0, "R7 low before settle ignored", tx_err, 0);

    // tolerance-dependent window end
    inject_and_expect(1'b0, 1'b1, 38, 1'b0, "R7 extended window closed at 37");
    inject_and_expect(1'b0, 1'b1, 36, 1'b1, "R3 extended window open at 36");
    inject_and_expect(1'b0, 1'b0, 38, 1'b1, "R3 standard window open at 38");
    inject_and_expect(1'b1, 1'b0, 42, 1'b0, "R7 standard window closed at 41");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule